// File: doc/BRIEF.md
# TRB Ring Producer with Cycle-Bit Ownership

This block is the producing side of a circular work ring made of 16-byte transfer request blocks (TRBs). The ring is split into one or more memory segments. Software-side logic feeds it payloads over a valid/ready stream. Each payload carries a "more follows" flag, and a descriptor that spans several buffers is sent as a run of payloads whose flag is set on every one except the last. For each accepted payload the block writes one complete entry to a synchronous memory write port, in the same cycle.

The consumer never compares head and tail pointers to find new work. It tests each entry's cycle bit against its own cycle state. The producer stamps every entry it writes with its current cycle state. The last slot of every segment is taken up by a link entry that points to the next segment's base address, and the link that closes the last segment also tells the consumer to flip its state. The producer flips its own state once per lap, right after writing that closing link.

The consumer reports its dequeue position back as a segment and slot number. From that position the block derives full and empty status. One cycle after the last entry of a descriptor is written, the block raises a one-cycle doorbell pulse.

Top module: `trb_ring_producer`

## Requirements
- R1: While reset is asserted, and until the reset release has passed two clock edges, `s_ready` and `mem_we` are 0. After reset, `cycle_state` is 1, `doorbell` is 0, and the enqueue position is segment 0, slot 0. With the dequeue position also at 0/0, `ring_empty` is 1 and `ring_full` is 0.
- R2: An accepted payload (`s_valid` and `s_ready` both high) is written in the same cycle. The write address is `base[seg] + 16*slot`. The data is `{payload[123:0], 1'b0, 1'b0, more, cycle_state}`: bit 0 is the cycle bit, bit 1 is the chain bit, bit 2 is the toggle flag and bit 3 is the link flag.
- R3: When the enqueue position is at the last slot (`SEG_ENTRIES-1`) of a segment, `s_ready` is 0. If the ring is not full, the block writes a link entry there by itself. The link entry has bit 3 set, the next segment's base in bits `[4 +: ADDR_W]` (the last segment points to segment 0), bit 1 clear, bit 0 equal to `cycle_state`, and all other bits zero.
- R4: Bit 2 of a link entry is set only on the link that closes the last segment. `cycle_state` inverts in the cycle after that link is written, and it changes at no other time.
- R5: When the slot after the enqueue position equals the dequeue position, `ring_full` is 1, `s_ready` is 0 and nothing is written. A payload offered in that state is not taken: the write port stays idle and the same payload is written once space opens.
- R6: `ring_empty` is 1 exactly when the enqueue position equals the dequeue position.
- R7: `doorbell` is high for one cycle, in the cycle after a payload with `more` = 0 is written. It stays low after payloads with `more` = 1 and after link entries.
- R8: The ring has `NUM_SEGS*SEG_ENTRIES` slots, and the default is 16. Because one slot is always kept free, starting from an empty ring with no dequeue progress, exactly `NUM_SEGS*SEG_ENTRIES-1` entries (links included) are written before the ring reports full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| seg_base_flat | input | NUM_SEGS*ADDR_W | Byte base address of each segment, segment g at bits [g*ADDR_W +: ADDR_W] |
| deq_seg | input | SEG_W | Consumer dequeue segment |
| deq_idx | input | IDX_W | Consumer dequeue slot within the segment |
| s_valid | input | 1 | Payload offered |
| s_more | input | 1 | More entries of this descriptor follow (written as the chain bit) |
| s_payload | input | 124 | Entry body |
| s_ready | output | 1 | Payload accepted this cycle if valid |
| mem_we | output | 1 | Ring memory write strobe |
| mem_addr | output | ADDR_W | Byte address of the entry being written |
| mem_wdata | output | 128 | Entry contents |
| ring_full | output | 1 | Next slot is the consumer's slot |
| ring_empty | output | 1 | Enqueue position equals dequeue position |
| cycle_state | output | 1 | Producer cycle state |
| doorbell | output | 1 | One-cycle notification after a descriptor's final entry |

## Verification
A wrong enqueue position shows up in `mem_addr` on the very next write, and it shows up in `ring_full` or `ring_empty` as soon as the consumer's position comes near. A cycle state that is off by one lap shows at once in bit 0 of every entry written afterwards and in `cycle_state`. A missed or extra link entry shifts every later address and the segment-boundary link pattern. A doorbell fault is visible one cycle after the descriptor's last write. The bench runs its own model alongside the design and compares all outputs every cycle, so each of these faults is reported in the cycle it first appears.

// File: rtl/trb_ring_pkg.sv
package trb_ring_pkg;
  localparam int unsigned TRB_W      = 128;
  localparam int unsigned TRB_BYTES  = TRB_W / 8;
  localparam int unsigned CYC_BIT    = 0;
  localparam int unsigned CHAIN_BIT  = 1;
  localparam int unsigned TOGGLE_BIT = 2;
  localparam int unsigned LINK_BIT   = 3;
  localparam int unsigned BODY_LSB   = 4;
  localparam int unsigned PAY_W      = TRB_W - BODY_LSB;

  function automatic int unsigned width_for(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/trb_rst_sync.sv
module trb_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);
  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb sync_d = {sync_q[0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= sync_d;
  end

  assign srst_n = sync_q[1];
endmodule

// File: rtl/trb_enq_ptr.sv
module trb_enq_ptr #(
  parameter int unsigned NUM_SEGS    = 2,
  parameter int unsigned SEG_ENTRIES = 8,
  parameter int unsigned SEG_W       = 1,
  parameter int unsigned IDX_W       = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  input  logic [SEG_W-1:0] deq_seg,
  input  logic [IDX_W-1:0] deq_idx,
  output logic [SEG_W-1:0] seg,
  output logic [IDX_W-1:0] idx,
  output logic [SEG_W-1:0] nxt_seg,
  output logic             cyc,
  output logic             at_link,
  output logic             last_seg,
  output logic             blocked,
  output logic             empty
);
  logic [SEG_W-1:0] seg_q, seg_d;
  logic [IDX_W-1:0] idx_q, idx_d, nidx;
  logic             cyc_q, cyc_d;

  always_comb begin
    at_link  = (idx_q == IDX_W'(SEG_ENTRIES - 1));
    last_seg = (seg_q == SEG_W'(NUM_SEGS - 1));
    if (at_link) begin
      nxt_seg = last_seg ? '0 : seg_q + 1'b1;
      nidx    = '0;
    end else begin
      nxt_seg = seg_q;
      nidx    = idx_q + 1'b1;
    end
    blocked = (nxt_seg == deq_seg) && (nidx == deq_idx);
    empty   = (seg_q == deq_seg) && (idx_q == deq_idx);
  end

  always_comb begin
    seg_d = seg_q;
    idx_d = idx_q;
    cyc_d = cyc_q;
    if (adv) begin
      seg_d = nxt_seg;
      idx_d = nidx;
      if (at_link && last_seg) cyc_d = ~cyc_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seg_q <= '0;
      idx_q <= '0;
      cyc_q <= 1'b1;
    end else begin
      seg_q <= seg_d;
      idx_q <= idx_d;
      cyc_q <= cyc_d;
    end
  end

  assign seg = seg_q;
  assign idx = idx_q;
  assign cyc = cyc_q;
endmodule

// File: rtl/trb_entry_fmt.sv
module trb_entry_fmt
  import trb_ring_pkg::*;
#(
  parameter int unsigned NUM_SEGS = 2,
  parameter int unsigned ADDR_W   = 32,
  parameter int unsigned SEG_W    = 1,
  parameter int unsigned IDX_W    = 3
) (
  input  logic [NUM_SEGS*ADDR_W-1:0] seg_base_flat,
  input  logic [SEG_W-1:0]           seg,
  input  logic [IDX_W-1:0]           idx,
  input  logic [SEG_W-1:0]           nxt_seg,
  input  logic                       cyc,
  input  logic                       at_link,
  input  logic                       last_seg,
  input  logic                       more,
  input  logic [PAY_W-1:0]           payload,
  output logic [ADDR_W-1:0]          addr,
  output logic [TRB_W-1:0]           wdata
);
  localparam int unsigned SHIFT = $clog2(TRB_BYTES);

  logic [ADDR_W-1:0] base_a [NUM_SEGS];

  for (genvar g = 0; g < NUM_SEGS; g++) begin : g_base
    assign base_a[g] = seg_base_flat[g*ADDR_W +: ADDR_W];
  end

  always_comb begin
    addr  = base_a[seg] + ADDR_W'({idx, {SHIFT{1'b0}}});
    wdata = '0;
    wdata[CYC_BIT] = cyc;
    if (at_link) begin
      wdata[LINK_BIT]              = 1'b1;
      wdata[TOGGLE_BIT]            = last_seg;
      wdata[BODY_LSB +: ADDR_W]    = base_a[nxt_seg];
    end else begin
      wdata[CHAIN_BIT]             = more;
      wdata[TRB_W-1:BODY_LSB]      = payload;
    end
  end
endmodule

// File: rtl/trb_bell.sv
module trb_bell (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  output logic pulse
);
  logic pulse_q, pulse_d;

  always_comb pulse_d = fire;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pulse_q <= 1'b0;
    else        pulse_q <= pulse_d;
  end

  assign pulse = pulse_q;
endmodule

// File: rtl/trb_ring_producer.sv
module trb_ring_producer
  import trb_ring_pkg::*;
#(
  parameter int unsigned NUM_SEGS    = 2,
  parameter int unsigned SEG_ENTRIES = 8,
  parameter int unsigned ADDR_W      = 32,
  localparam int unsigned SEG_W      = width_for(NUM_SEGS),
  localparam int unsigned IDX_W      = width_for(SEG_ENTRIES)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NUM_SEGS*ADDR_W-1:0] seg_base_flat,
  input  logic [SEG_W-1:0]           deq_seg,
  input  logic [IDX_W-1:0]           deq_idx,
  input  logic                       s_valid,
  input  logic                       s_more,
  input  logic [PAY_W-1:0]           s_payload,
  output logic                       s_ready,
  output logic                       mem_we,
  output logic [ADDR_W-1:0]          mem_addr,
  output logic [TRB_W-1:0]           mem_wdata,
  output logic                       ring_full,
  output logic                       ring_empty,
  output logic                       cycle_state,
  output logic                       doorbell
);
  logic             live;
  logic [SEG_W-1:0] seg, nxt_seg;
  logic [IDX_W-1:0] idx;
  logic             at_link, last_seg, blocked, write_en;

  trb_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .srst_n(live));

  trb_enq_ptr #(
    .NUM_SEGS(NUM_SEGS), .SEG_ENTRIES(SEG_ENTRIES), .SEG_W(SEG_W), .IDX_W(IDX_W)
  ) u_ptr (
    .clk(clk), .rst_n(rst_n), .adv(write_en),
    .deq_seg(deq_seg), .deq_idx(deq_idx),
    .seg(seg), .idx(idx), .nxt_seg(nxt_seg), .cyc(cycle_state),
    .at_link(at_link), .last_seg(last_seg), .blocked(blocked), .empty(ring_empty)
  );

  trb_entry_fmt #(
    .NUM_SEGS(NUM_SEGS), .ADDR_W(ADDR_W), .SEG_W(SEG_W), .IDX_W(IDX_W)
  ) u_fmt (
    .seg_base_flat(seg_base_flat), .seg(seg), .idx(idx), .nxt_seg(nxt_seg),
    .cyc(cycle_state), .at_link(at_link), .last_seg(last_seg),
    .more(s_more), .payload(s_payload), .addr(mem_addr), .wdata(mem_wdata)
  );

  always_comb begin
    s_ready  = live && !at_link && !blocked;
    write_en = live && !blocked && (at_link || s_valid);
  end

  trb_bell u_bell (
    .clk(clk), .rst_n(rst_n),
    .fire(write_en && !at_link && !s_more),
    .pulse(doorbell)
  );

  assign mem_we    = write_en;
  assign ring_full = blocked;
endmodule

// File: rtl/trb_ring_producer_chk.sv
module trb_ring_producer_chk (
  input logic         clk,
  input logic         rst_n,
  input logic         s_ready,
  input logic         mem_we,
  input logic [127:0] mem_wdata,
  input logic         ring_full,
  input logic         ring_empty,
  input logic         cycle_state,
  input logic         doorbell
);
  a_r5_no_write_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    ring_full |-> (!mem_we && !s_ready));

  a_r3_link_blocks_input: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && mem_wdata[3]) |-> !s_ready);

  a_r2_cycle_stamp: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (mem_wdata[0] == cycle_state));

  a_r4_flip_after_close: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && mem_wdata[3] && mem_wdata[2]) |=> (cycle_state != $past(cycle_state)));

  a_r4_no_stray_flip: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cycle_state) |-> $past(mem_we && mem_wdata[3] && mem_wdata[2]));

  a_r7_bell_follows_last: assert property (@(posedge clk) disable iff (!rst_n)
    doorbell |-> $past(mem_we && !mem_wdata[3] && !mem_wdata[1]));

  a_r7_last_rings_bell: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && !mem_wdata[3] && !mem_wdata[1]) |=> doorbell);

  a_r6_not_both: assert property (@(posedge clk) disable iff (!rst_n)
    !(ring_full && ring_empty));
endmodule

bind trb_ring_producer trb_ring_producer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .s_ready(s_ready), .mem_we(mem_we),
  .mem_wdata(mem_wdata), .ring_full(ring_full), .ring_empty(ring_empty),
  .cycle_state(cycle_state), .doorbell(doorbell)
);

// File: tb/trb_ring_producer_bench.sv
`timescale 1ns/1ps
module trb_ring_producer_bench;
  localparam int NS = 2;
  localparam int SE = 8;
  localparam int AW = 32;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [NS*AW-1:0] seg_base_flat;
  logic [0:0]      deq_seg = '0;
  logic [2:0]      deq_idx = '0;
  logic            s_valid = 1'b0;
  logic            s_more = 1'b0;
  logic [123:0]    s_payload = '0;
  logic            s_ready, mem_we, ring_full, ring_empty, cycle_state, doorbell;
  logic [AW-1:0]   mem_addr;
  logic [127:0]    mem_wdata;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  int es = 0, ei = 0, ds = 0, di = 0;
  bit cyc = 1'b1, db_exp = 1'b0;
  int writes_phase_a = 0;
  logic [AW-1:0] base [NS];

  always #2 clk = ~clk;

  trb_ring_producer u_trb_ring_producer (
    .clk(clk), .rst_n(rst_n), .seg_base_flat(seg_base_flat),
    .deq_seg(deq_seg), .deq_idx(deq_idx), .s_valid(s_valid), .s_more(s_more),
    .s_payload(s_payload), .s_ready(s_ready), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .ring_full(ring_full), .ring_empty(ring_empty),
    .cycle_state(cycle_state), .doorbell(doorbell)
  );

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // one cycle: compare outputs with the model, then advance the model
  task automatic step_model(input bit count_a);
    bit at_link, blocked, we;
    int ns, ni;
    logic [127:0] ex;
    at_link = (ei == SE - 1);
    ns = at_link ? (es + 1) % NS : es;
    ni = at_link ? 0 : ei + 1;
    blocked = (ns == ds) && (ni == di);
    we = !blocked && (at_link || s_valid);
    chk("R6 empty", ring_empty, (es == ds) && (ei == di));
    chk("R5 full", ring_full, blocked);
    chk(at_link ? "R3 ready at link" : "R5 ready", s_ready, !at_link && !blocked);
    chk(at_link ? "R3 link write" : "R5 write strobe", mem_we, we);
    chk("R7 doorbell", doorbell, db_exp);
    chk("R4 cycle state", cycle_state, cyc);
    if (we) begin
      ex = '0;
      if (at_link) begin
        ex[4 +: AW] = base[ns];
        ex[3] = 1'b1;
        ex[2] = (es == NS - 1);
        ex[0] = cyc;
      end else begin
        ex = {s_payload, 1'b0, 1'b0, s_more, cyc};
      end
      chk("R2 address", mem_addr, base[es] + AW'(16 * ei));
      chk(at_link ? "R3 link entry" : "R2 entry data", mem_wdata, ex);
      if (count_a) writes_phase_a++;
      if (at_link && es == NS - 1) cyc = !cyc;
      es = ns;
      ei = ni;
    end
    db_exp = we && !at_link && !s_more;
  endtask

  task automatic consumer_step();
    if (!(ds == es && di == ei)) begin
      if (di == SE - 1) begin ds = (ds + 1) % NS; di = 0; end
      else di = di + 1;
    end
  endtask

  initial begin
    base[0] = 32'h0000_1000;
    base[1] = 32'h0004_8000;
    seg_base_flat = {base[1], base[0]};
    repeat (3) @(negedge clk);
    #1;
    chk("R1 ready in reset", s_ready, 1'b0);
    chk("R1 write in reset", mem_we, 1'b0);
    chk("R1 cycle state", cycle_state, 1'b1);
    chk("R1 empty", ring_empty, 1'b1);
    chk("R1 full", ring_full, 1'b0);
    chk("R1 doorbell", doorbell, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk("R1 ready held after release", s_ready, 1'b0);
    @(negedge clk);
    // phase A: consumer stalled at 0/0, producer fills the ring
    for (int c = 0; c < 25; c++) begin
      @(negedge clk);
      s_valid = 1'b1;
      s_more = c[0];
      s_payload = {$urandom, $urandom, $urandom, $urandom};
      #1;
      step_model(1'b1);
    end
    chk("R8 entries before full", writes_phase_a, NS * SE - 1);
    chk("R5 full reported", ring_full, 1'b1);
    // phase B: random traffic with a moving consumer
    for (int c = 0; c < 600; c++) begin
      @(negedge clk);
      if (($urandom % 10) < 6) consumer_step();
      deq_seg = ds[0:0];
      deq_idx = di[2:0];
      s_valid = (($urandom % 4) != 0);
      s_more = $urandom % 2;
      s_payload = {$urandom, $urandom, $urandom, $urandom};
      #1;
      step_model(1'b0);
    end
    // phase C: drain to empty
    for (int c = 0; c < 40; c++) begin
      @(negedge clk);
      consumer_step();
      deq_seg = ds[0:0];
      deq_idx = di[2:0];
      s_valid = 1'b0;
      #1;
      step_model(1'b0);
    end
    chk("R6 drained", ring_empty, 1'b1);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule